// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block divides an input clock by a whole number from 2 to 8 and can be pulled to a known phase by an external alignment pulse. When the same pulse reaches several copies of the block, their divided clocks rise on the same input edge. Software sets the ratio and the alignment behaviour with a single 8-bit configuration word.

Even ratios give a divided clock with an exact 50% duty cycle. Odd ratios stretch the high phase by half an input period. The extra half period is timed from the falling input edge, so the duty cycle then follows the duty cycle of the input clock. A ratio written while the divider runs is applied only when the current output period ends. The alignment pulse can re-align the divider on every rising edge. It can instead act once per configuration write, and a status output shows whether that single pulse has been used.

Top module: `sync_clk_divider`

## Requirements
- R1: The ratio N is taken from configuration bits [7:4]. Codes 0 and 1 give N=2, codes 9 to 15 give N=8, and codes 2 to 8 give N equal to the code.
- R2: For an even N, clk_div is high for exactly N/2 input periods and low for N/2 input periods. This is N half-periods high and N half-periods low.
- R3: For an odd N, clk_div is high for (N-1)/2 input periods plus one half period, with the extension ending on a falling input edge. It is low for the same length, so each output period lasts N input periods.
- R4: Configuration bit 1 enables alignment. While it is 0, sync_in has no effect on the output phase.
- R5: sync_in passes through a two-stage synchronizer, and an event is a rising edge at the synchronizer output. When an event is accepted, the divider restarts with the latest written ratio. clk_div is low after the falling input edge that follows the third rising input edge at which sync_in is seen high. clk_div rises on the fourth such rising edge.
- R6: When configuration bit 2 is 0, every accepted event re-aligns the divider.
- R7: When configuration bit 2 is 1, only the first event after a configuration write re-aligns the divider. Each write re-arms the block for exactly one more event, including a write made in the cycle that registers the pulse.
- R8: oneshot_done is 0 after reset and after every configuration write. It becomes 1 once the single event has been accepted in the mode set by bit 2.
- R9: A ratio written without an alignment event lets the current output period finish at the old ratio. The new ratio starts at the next period boundary, so no pulse is shortened.
- R10: rst is synchronous and active high. It forces clk_div and oneshot_done low, sets the ratio to 2 and disables alignment. clk_div rises on the first rising input edge after rst is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to divide |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wdata | input | 8 | Configuration word: [7:4] ratio code, [2] single-event mode, [1] alignment enable |
| sync_in | input | 1 | Asynchronous alignment pulse |
| clk_div | output | 1 | Divided clock |
| oneshot_done | output | 1 | Single alignment event used since the last write |

## Verification
The assertions assume that sync_in holds each level for at least one full input cycle. They also assume that cfg_we is a single-cycle strobe that is never held high, so that a synchronized rising edge and a write refer to well-defined register states. The stimulus drives every input half a cycle away from the capturing edge. Each alignment pulse lasts exactly one input period, and each write strobe lasts exactly one period. Single-event and disable checks are timed against a known phase after an earlier alignment, so an accepted event and an ignored one give different output values.

// File: rtl/sync_clk_divider_pkg.sv
`timescale 1ns/1ps
package sync_clk_divider_pkg;

    localparam int RATIO_MIN   = 2;
    localparam int RATIO_MAX   = 8;
    localparam int RATIO_W     = $clog2(RATIO_MAX + 1);
    localparam int CFG_W       = 8;
    localparam int CODE_LSB    = 4;
    localparam int CODE_W      = 4;
    localparam int EN_BIT      = 1;
    localparam int ONESHOT_BIT = 2;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t ratio;
        logic   one_shot;
        logic   sync_en;
    } div_cfg_t;

    typedef struct packed {
        ratio_t cnt;
        logic   restart;
        logic   pos_hi;
        ratio_t ratio;
    } div_state_t;

    function automatic ratio_t clamp_ratio(input logic [CODE_W-1:0] code);
        if (int'(code) < RATIO_MIN)
            return ratio_t'(RATIO_MIN);
        else if (int'(code) > RATIO_MAX)
            return ratio_t'(RATIO_MAX);
        else
            return ratio_t'(code);
    endfunction

    function automatic div_cfg_t decode_cfg(input logic [CFG_W-1:0] word);
        div_cfg_t c;
        c.ratio    = clamp_ratio(word[CODE_LSB +: CODE_W]);
        c.one_shot = word[ONESHOT_BIT];
        c.sync_en  = word[EN_BIT];
        return c;
    endfunction

endpackage

// File: rtl/sync_clk_divider_syncin.sv
`timescale 1ns/1ps
module sync_clk_divider_syncin #(
    parameter int STAGES = 2
) (
    input  logic clk_in,
    input  logic rst,
    input  logic sync_async,
    output logic sync_rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk_in) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= sync_async;
                end
            end else begin : g_next
                always_ff @(posedge clk_in) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_in) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign sync_rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/sync_clk_divider_ctrl.sv
`timescale 1ns/1ps
module sync_clk_divider_ctrl
    import sync_clk_divider_pkg::*;
(
    input  logic             clk_in,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             sync_rise,
    output div_cfg_t         cfg_q,
    output logic             sync_take,
    output logic             oneshot_done
);
    logic armed_q;

    assign sync_take = sync_rise & cfg_q.sync_en & (~cfg_q.one_shot | armed_q);

    always_ff @(posedge clk_in) begin
        if (rst) begin
            cfg_q.ratio    <= ratio_t'(RATIO_MIN);
            cfg_q.one_shot <= 1'b0;
            cfg_q.sync_en  <= 1'b0;
            armed_q        <= 1'b1;
            oneshot_done   <= 1'b0;
        end else if (cfg_we) begin
            cfg_q          <= decode_cfg(cfg_wdata);
            armed_q        <= 1'b1;
            oneshot_done   <= 1'b0;
        end else if (sync_take && cfg_q.one_shot) begin
            armed_q        <= 1'b0;
            oneshot_done   <= 1'b1;
        end
    end
endmodule

// File: rtl/sync_clk_divider_core.sv
`timescale 1ns/1ps
module sync_clk_divider_core
    import sync_clk_divider_pkg::*;
(
    input  logic       clk_in,
    input  logic       rst,
    input  logic       sync_take,
    input  ratio_t     ratio_cfg,
    output div_state_t st,
    output logic       neg_hi
);
    localparam ratio_t ONE = ratio_t'(1);

    div_state_t st_n;
    ratio_t     cnt_inc;
    logic       at_end;

    assign cnt_inc = st.cnt + ONE;
    assign at_end  = (st.cnt == st.ratio - ONE);

    always_comb begin
        st_n = st;
        if (sync_take) begin
            st_n.cnt     = '0;
            st_n.restart = 1'b1;
            st_n.pos_hi  = 1'b0;
            st_n.ratio   = ratio_cfg;
        end else if (st.restart) begin
            st_n.cnt     = '0;
            st_n.restart = 1'b0;
            st_n.pos_hi  = 1'b1;
        end else if (at_end) begin
            st_n.cnt     = '0;
            st_n.pos_hi  = 1'b1;
            st_n.ratio   = ratio_cfg;
        end else begin
            st_n.cnt     = cnt_inc;
            st_n.pos_hi  = (cnt_inc < (st.ratio >> 1));
        end
    end

    always_ff @(posedge clk_in) begin
        if (rst) begin
            st.cnt     <= '0;
            st.restart <= 1'b1;
            st.pos_hi  <= 1'b0;
            st.ratio   <= ratio_t'(RATIO_MIN);
        end else begin
            st <= st_n;
        end
    end

    // half-period extension for odd ratios, launched on the falling edge
    always_ff @(negedge clk_in) begin
        if (rst) neg_hi <= 1'b0;
        else     neg_hi <= st.pos_hi;
    end
endmodule

// File: rtl/sync_clk_divider.sv
`timescale 1ns/1ps
module sync_clk_divider
    import sync_clk_divider_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_in,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             sync_in,
    output logic             clk_div,
    output logic             oneshot_done
);
    logic       sync_rise;
    logic       sync_take;
    logic       neg_hi;
    div_cfg_t   cfg_q;
    div_state_t div_st;

    sync_clk_divider_syncin #(.STAGES(SYNC_STAGES)) u_syncin (
        .clk_in     (clk_in),
        .rst        (rst),
        .sync_async (sync_in),
        .sync_rise  (sync_rise)
    );

    sync_clk_divider_ctrl u_ctrl (
        .clk_in       (clk_in),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .sync_rise    (sync_rise),
        .cfg_q        (cfg_q),
        .sync_take    (sync_take),
        .oneshot_done (oneshot_done)
    );

    sync_clk_divider_core u_core (
        .clk_in    (clk_in),
        .rst       (rst),
        .sync_take (sync_take),
        .ratio_cfg (cfg_q.ratio),
        .st        (div_st),
        .neg_hi    (neg_hi)
    );

    assign clk_div = div_st.pos_hi | (neg_hi & div_st.ratio[0]);
endmodule

// File: rtl/sync_clk_divider_chk.sv
`timescale 1ns/1ps
module sync_clk_divider_chk
    import sync_clk_divider_pkg::*;
(
    input logic       clk_in,
    input logic       rst,
    input logic       cfg_we,
    input logic       sync_take,
    input logic       oneshot_done,
    input div_cfg_t   cfg,
    input div_state_t st
);
    assert_ratio_range_R1: assert property (@(posedge clk_in) disable iff (rst)
        (int'(st.ratio) >= RATIO_MIN) && (int'(st.ratio) <= RATIO_MAX));

    assert_disabled_ignored_R4: assert property (@(posedge clk_in) disable iff (rst)
        !cfg.sync_en |-> !sync_take);

    assert_realign_R5: assert property (@(posedge clk_in) disable iff (rst)
        sync_take |=> (!st.pos_hi && st.restart) ##1 st.pos_hi);

    assert_single_event_R7: assert property (@(posedge clk_in) disable iff (rst)
        (cfg.one_shot && oneshot_done) |-> !sync_take);

    assert_flag_cleared_R8: assert property (@(posedge clk_in) disable iff (rst)
        cfg_we |=> !oneshot_done);

    assert_ratio_held_R9: assert property (@(posedge clk_in) disable iff (rst)
        (!sync_take && (st.cnt != st.ratio - ratio_t'(1))) |=> $stable(st.ratio));
endmodule

bind sync_clk_divider sync_clk_divider_chk u_chk (
    .clk_in       (clk_in),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .sync_take    (sync_take),
    .oneshot_done (oneshot_done),
    .cfg          (cfg_q),
    .st           (div_st)
);

// File: tb/sync_clk_divider_bench.sv
`timescale 1ns/1ps
module sync_clk_divider_bench;
    logic       clk_in = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       sync_in = 1'b0;
    logic       clk_div;
    logic       oneshot_done;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    sync_clk_divider u_sync_clk_divider (
        .clk_in       (clk_in),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .sync_in      (sync_in),
        .clk_div      (clk_div),
        .oneshot_done (oneshot_done)
    );

    always #2.5 clk_in = ~clk_in;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ratio code [7:4], single-event bit 2, enable bit 1
    function automatic logic [7:0] cfg_word(input int code, input bit os, input bit en);
        logic [3:0] c;
        c = code[3:0];
        return {c, 1'b0, os, en, 1'b0};
    endfunction

    task automatic write_cfg(input logic [7:0] w);
        @(negedge clk_in) #1;
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk_in) #1;
        cfg_we = 1'b0;
    endtask

    // one-period pulse; output low after third edge, high after fourth
    task automatic align(input string req);
        @(negedge clk_in) #1 sync_in = 1'b1;
        @(negedge clk_in) #1 sync_in = 1'b0;
        @(posedge clk_in) #1;
        @(posedge clk_in) #1;
        @(negedge clk_in) #1 check(req, clk_div, 0);
        @(posedge clk_in) #1 check(req, clk_div, 1);
    endtask

    // called just after an aligned rise with N=8; a taken pulse gives 1, an ignored one 0
    task automatic pulse_after(input string req, input bit wr, input logic [7:0] w, input int exp);
        @(negedge clk_in) #1;
        sync_in = 1'b1;
        if (wr) begin
            cfg_we = 1'b1;
            cfg_wdata = w;
        end
        @(negedge clk_in) #1;
        sync_in = 1'b0;
        cfg_we = 1'b0;
        @(posedge clk_in) #1;
        @(posedge clk_in) #1;
        @(posedge clk_in) #1 check(req, clk_div, exp);
    endtask

    // counts half-period samples high from now, then low, ending on the next rise
    task automatic measure(output int hi, output int lo);
        hi = 0;
        lo = 0;
        while (clk_div) begin
            hi++;
            @(clk_in) #1;
        end
        while (!clk_div) begin
            lo++;
            @(clk_in) #1;
        end
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi, lo;
        // R10 reset state
        repeat (4) @(posedge clk_in);
        @(negedge clk_in) #1;
        check("R10 clk_div in reset", clk_div, 0);
        check("R10 flag in reset", oneshot_done, 0);
        rst = 1'b0;
        @(posedge clk_in) #1 check("R10 first rise", clk_div, 1);
        measure(hi, lo);
        check("R10 default ratio high", hi, 2);
        check("R10 default ratio low", lo, 2);

        // R1 R2 R3 R5 sweep over every ratio code
        for (int code = 0; code < 16; code++) begin
            int    n;
            string req;
            n = (code < 2) ? 2 : ((code > 8) ? 8 : code);
            req = (code < 2 || code > 8) ? "R1" : ((n % 2 == 0) ? "R2" : "R3");
            write_cfg(cfg_word(code, 1'b0, 1'b1));
            align("R5 align");
            for (int p = 0; p < 2; p++) begin
                measure(hi, lo);
                check({req, " high halves"}, hi, n);
                check({req, " low halves"}, lo, n);
            end
        end

        // R9 ratio change mid-period
        write_cfg(cfg_word(4, 1'b0, 1'b1));
        align("R5 align");
        cfg_we = 1'b1;
        cfg_wdata = cfg_word(7, 1'b0, 1'b1);
        @(posedge clk_in) #1 cfg_we = 1'b0;
        measure(hi, lo);
        check("R9 old period high", hi, 2);
        check("R9 old period low", lo, 4);
        measure(hi, lo);
        check("R9 new period high", hi, 7);
        check("R9 new period low", lo, 7);

        // R6 every-event mode, then R4 disable
        write_cfg(cfg_word(8, 1'b0, 1'b1));
        align("R6 align");
        pulse_after("R6 second event", 1'b0, 8'h00, 1);
        pulse_after("R6 third event", 1'b0, 8'h00, 1);
        pulse_after("R4 disabled event", 1'b1, cfg_word(8, 1'b0, 1'b0), 0);

        // R7 R8 single-event mode
        write_cfg(cfg_word(8, 1'b1, 1'b1));
        check("R8 flag after write", oneshot_done, 0);
        align("R7 first event");
        check("R8 flag after event", oneshot_done, 1);
        pulse_after("R7 second event ignored", 1'b0, 8'h00, 0);
        check("R8 flag held", oneshot_done, 1);
        pulse_after("R7 rearm with event", 1'b1, cfg_word(8, 1'b1, 1'b1), 1);
        check("R8 flag after rearmed event", oneshot_done, 1);
        pulse_after("R7 after rearm ignored", 1'b0, 8'h00, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule